// File: doc/BRIEF.md
# Hot-Swap Gate Enable Sequencer

This block decides, cycle by cycle, whether the external pass transistor of a hot-swap power path may be driven on. It receives six digitized comparator levels (input voltage above the undervoltage point, input above the overvoltage point, supply lockout released, current limit active, drain near the negative rail, and gate close to its full drive), plus a single-cycle breaker-trip pulse from a separate overcurrent integrator. It produces a gate enable, a request to regulate the gate downward while current limiting is active, a latched power-good level with selectable polarity, and a flag that shows the breaker fault is latched.

The six comparator levels are asynchronous. Each one passes through a two-flop synchronizer before any decision uses it. A breaker trip holds the gate off for a latch-off interval that is set in clock cycles. The fault is cleared by a low-then-high cycle on the undervoltage input, and that cycle may happen during the interval. A loss of supply lockout clears everything at once.

Top module: `hsgs_gate_seq`

## Requirements
- R1: During and after a synchronous active-high reset, gate_en, reg_down and fault_latched are 0 and pgood sits at its inactive level.
- R2: From the off state, gate_en rises 3 clock edges after the inputs start to show uv_ok=1, ov=0, lockout_ok=1 and ilim=0 together. While ilim=1 the gate does not start.
- R3: ov=1 or uv_ok=0 on an enabled gate drops gate_en on the 3rd clock edge after the input change, with no added delay.
- R4: While the gate is enabled, ilim=1 raises reg_down (3 edges of latency) and leaves gate_en high. reg_down is never high while gate_en is low.
- R5: A trip pulse while the gate is enabled and lockout is released sets fault_latched and clears gate_en on the next clock edge.
- R6: Once set, fault_latched stays high, with gate_en low, for at least LATCH_CYCLES clock cycles.
- R7: The fault clears only after the synchronized uv_ok has been seen low during the latched state and is then high. A low-then-high cycle made early in the interval is remembered. Without such a cycle the fault holds for as long as it lasts.
- R8: lockout_ok=0 clears fault_latched, the latch-off count and gate_en within 3 edges, whatever time remains in the interval.
- R9: The power-good latch sets when drain_low and gate_full are both 1 while the gate is enabled. It stays set after those flags drop, and it clears on the same edge on which gate_en falls.
- R10: With PG_ACTIVE_LOW=1, pgood is 0 when power is good and 1 otherwise. With PG_ACTIVE_LOW=0 the levels are the other way round.
- R11: A trip pulse while the gate is off is ignored: fault_latched stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_ok_a | input | 1 | Async: input voltage above the undervoltage point |
| ov_a | input | 1 | Async: input voltage above the overvoltage point |
| lockout_ok_a | input | 1 | Async: supply lockout released |
| ilim_a | input | 1 | Async: sensed current at or above the limit |
| drain_low_a | input | 1 | Async: drain near the negative rail |
| gate_full_a | input | 1 | Async: gate near its full drive |
| trip | input | 1 | Synchronous single-cycle breaker-trip pulse |
| gate_en | output | 1 | Pass transistor gate drive enable |
| reg_down | output | 1 | Request to pull the gate down for current regulation |
| pgood | output | 1 | Latched power-good, polarity set by PG_ACTIVE_LOW |
| fault_latched | output | 1 | Breaker fault latched, gate held off |

## Verification
An asynchronous input reaches the outputs after three clock edges: two synchronizer flops and one output register. A trip pulse is synchronous and acts on the next edge. The bench changes inputs just after a falling edge and samples outputs at the following falling edge. A reference model steps once per rising edge and keeps its own two-deep delay of the inputs, so each expected value lines up with the edge at which the design must show it. The directed checks count those edges explicitly: three steps for a comparator effect, one for a trip, and exactly LATCH_CYCLES steps of fault hold before release.

// File: rtl/hsgs_pkg.sv
package hsgs_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RAMP    = 2'd1,
    ST_ON      = 2'd2,
    ST_LATCHED = 2'd3
  } hsgs_state_e;

  localparam int FLAG_UV    = 0;
  localparam int FLAG_OV    = 1;
  localparam int FLAG_LK    = 2;
  localparam int FLAG_ILIM  = 3;
  localparam int FLAG_DRAIN = 4;
  localparam int FLAG_GFULL = 5;
  localparam int NUM_FLAGS  = 6;
endpackage

// File: rtl/hsgs_sync.sv
module hsgs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsgs_latch_timer.sv
module hsgs_latch_timer #(
  parameter int CYCLES = 3200000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/hsgs_fsm.sv
module hsgs_fsm
  import hsgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        s_uv,
  input  logic        s_ov,
  input  logic        s_lk,
  input  logic        s_ilim,
  input  logic        s_drain,
  input  logic        s_gfull,
  input  logic        trip,
  input  logic        timer_done,
  output hsgs_state_e state_q,
  output hsgs_state_e state_n,
  output logic        timer_load
);
  logic rearm_q, rearm_n;
  logic supply_ok;
  logic start_ok;

  assign supply_ok = s_uv && !s_ov && s_lk;
  assign start_ok  = supply_ok && !s_ilim;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (start_ok) state_n = ST_RAMP;
      end
      ST_RAMP, ST_ON: begin
        if (!s_lk)                                      state_n = ST_OFF;
        else if (trip)                                  state_n = ST_LATCHED;
        else if (!s_uv || s_ov)                         state_n = ST_OFF;
        else if (state_q == ST_RAMP && s_drain && s_gfull) state_n = ST_ON;
      end
      ST_LATCHED: begin
        if (!s_lk)                                   state_n = ST_OFF;
        else if (timer_done && rearm_q && s_uv)      state_n = ST_OFF;
      end
      default: state_n = ST_OFF;
    endcase
  end

  // reset request on the undervoltage input is remembered while latched
  assign rearm_n    = (state_q == ST_LATCHED) && (state_n == ST_LATCHED) && (rearm_q || !s_uv);
  assign timer_load = (state_q != ST_LATCHED) && (state_n == ST_LATCHED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      rearm_q <= 1'b0;
    end else begin
      state_q <= state_n;
      rearm_q <= rearm_n;
    end
  end
endmodule

// File: rtl/hsgs_pgood.sv
module hsgs_pgood #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_now,
  input  logic gate_next,
  input  logic drain_low,
  input  logic gate_full,
  output logic good_q,
  output logic pin_q
);
  logic good_n;

  assign good_n = gate_next && (good_q || (gate_now && drain_low && gate_full));

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= 1'b0;
      pin_q  <= ACTIVE_LOW;
    end else begin
      good_q <= good_n;
      pin_q  <= ACTIVE_LOW ? !good_n : good_n;
    end
  end
endmodule

// File: rtl/hsgs_gate_seq.sv
module hsgs_gate_seq
  import hsgs_pkg::*;
#(
  parameter int LATCH_CYCLES  = 3200000,
  parameter bit PG_ACTIVE_LOW = 1'b1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_ok_a,
  input  logic ov_a,
  input  logic lockout_ok_a,
  input  logic ilim_a,
  input  logic drain_low_a,
  input  logic gate_full_a,
  input  logic trip,
  output logic gate_en,
  output logic reg_down,
  output logic pgood,
  output logic fault_latched
);
  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] s_flags;
  logic s_uv, s_ov, s_lk, s_ilim, s_drain, s_gfull;
  hsgs_state_e state_q, state_n;
  logic timer_load, timer_done;
  logic gate_n;
  logic pg_level;

  always_comb begin
    raw_flags             = '0;
    raw_flags[FLAG_UV]    = uv_ok_a;
    raw_flags[FLAG_OV]    = ov_a;
    raw_flags[FLAG_LK]    = lockout_ok_a;
    raw_flags[FLAG_ILIM]  = ilim_a;
    raw_flags[FLAG_DRAIN] = drain_low_a;
    raw_flags[FLAG_GFULL] = gate_full_a;
  end

  hsgs_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (s_flags)
  );

  assign s_uv    = s_flags[FLAG_UV];
  assign s_ov    = s_flags[FLAG_OV];
  assign s_lk    = s_flags[FLAG_LK];
  assign s_ilim  = s_flags[FLAG_ILIM];
  assign s_drain = s_flags[FLAG_DRAIN];
  assign s_gfull = s_flags[FLAG_GFULL];

  hsgs_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .s_uv       (s_uv),
    .s_ov       (s_ov),
    .s_lk       (s_lk),
    .s_ilim     (s_ilim),
    .s_drain    (s_drain),
    .s_gfull    (s_gfull),
    .trip       (trip),
    .timer_done (timer_done),
    .state_q    (state_q),
    .state_n    (state_n),
    .timer_load (timer_load)
  );

  hsgs_latch_timer #(.CYCLES(LATCH_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (timer_load),
    .run  (state_q == ST_LATCHED),
    .done (timer_done)
  );

  assign gate_n = (state_n == ST_RAMP) || (state_n == ST_ON);

  hsgs_pgood #(.ACTIVE_LOW(PG_ACTIVE_LOW)) u_pgood (
    .clk       (clk),
    .rst       (rst),
    .gate_now  (gate_en),
    .gate_next (gate_n),
    .drain_low (s_drain),
    .gate_full (s_gfull),
    .good_q    (pg_level),
    .pin_q     (pgood)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en       <= 1'b0;
      reg_down      <= 1'b0;
      fault_latched <= 1'b0;
    end else begin
      gate_en       <= gate_n;
      reg_down      <= gate_n && s_ilim;
      fault_latched <= (state_n == ST_LATCHED);
    end
  end
endmodule

// File: rtl/hsgs_gate_seq_chk.sv
module hsgs_gate_seq_chk #(
  parameter int LATCH_CYCLES = 3200000
) (
  input logic clk,
  input logic rst,
  input logic gate_en,
  input logic reg_down,
  input logic fault_latched,
  input logic pg_level,
  input logic s_uv,
  input logic s_ov,
  input logic s_lk,
  input logic trip
);
  logic [31:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)                hold_cnt <= '0;
    else if (fault_latched) hold_cnt <= (hold_cnt == 32'hFFFF_FFFF) ? hold_cnt : hold_cnt + 1;
    else                    hold_cnt <= '0;
  end

  assert_ov_kills_gate_R3: assert property (@(posedge clk) disable iff (rst)
    s_ov |=> !gate_en);

  assert_uv_kills_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !s_uv |=> !gate_en);

  assert_regdown_needs_gate_R4: assert property (@(posedge clk) disable iff (rst)
    reg_down |-> gate_en);

  assert_trip_latches_R5: assert property (@(posedge clk) disable iff (rst)
    (gate_en && trip && s_lk) |=> (fault_latched && !gate_en));

  assert_latched_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> !gate_en);

  assert_hold_window_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(fault_latched) && $past(s_lk)) |-> (hold_cnt >= LATCH_CYCLES));

  assert_lockout_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !s_lk |=> (!fault_latched && !gate_en));

  assert_pgood_needs_gate_R9: assert property (@(posedge clk) disable iff (rst)
    pg_level |-> gate_en);

  assert_trip_ignored_off_R11: assert property (@(posedge clk) disable iff (rst)
    (!gate_en && !fault_latched && trip) |=> !fault_latched);
endmodule

bind hsgs_gate_seq hsgs_gate_seq_chk #(.LATCH_CYCLES(LATCH_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .gate_en       (gate_en),
  .reg_down      (reg_down),
  .fault_latched (fault_latched),
  .pg_level      (pg_level),
  .s_uv          (s_uv),
  .s_ov          (s_ov),
  .s_lk          (s_lk),
  .trip          (trip)
);

// File: tb/hsgs_gate_seq_tb.sv
`timescale 1ns/1ps
module hsgs_gate_seq_tb;
  localparam int L = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv = 0, ov = 0, lk = 0, il = 0, dl = 0, gf = 0, trip = 0;
  logic gate_en, reg_down, pgood, fault_latched;
  logic gate_en_h, reg_down_h, pgood_h, fault_h;

  int total = 0;
  int bad = 0;

  // reference model state
  int   m_st = 0;         // 0 off, 1 ramp, 2 on, 3 latched
  int   m_cnt = 0;
  logic m_rearm = 0, m_gate = 0, m_reg = 0, m_fault = 0, m_pg = 0;
  logic [5:0] d1 = '0, d2 = '0;

  always #10 clk = ~clk;

  hsgs_gate_seq #(.LATCH_CYCLES(L), .PG_ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .rst(rst), .uv_ok_a(uv), .ov_a(ov), .lockout_ok_a(lk), .ilim_a(il),
    .drain_low_a(dl), .gate_full_a(gf), .trip(trip),
    .gate_en(gate_en), .reg_down(reg_down), .pgood(pgood), .fault_latched(fault_latched));

  hsgs_gate_seq #(.LATCH_CYCLES(L), .PG_ACTIVE_LOW(1'b0)) u_dut_hi (
    .clk(clk), .rst(rst), .uv_ok_a(uv), .ov_a(ov), .lockout_ok_a(lk), .ilim_a(il),
    .drain_low_a(dl), .gate_full_a(gf), .trip(trip),
    .gate_en(gate_en_h), .reg_down(reg_down_h), .pgood(pgood_h), .fault_latched(fault_h));

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic su, so, sl, si, sd, sg, sup_ok, gn, pgn;
    int nx;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_rearm = 0; m_gate = 0; m_reg = 0; m_fault = 0; m_pg = 0;
      d1 = '0; d2 = '0;
      return;
    end
    {sg, sd, si, sl, so, su} = d2;
    sup_ok = su && !so && sl;
    nx = m_st;
    case (m_st)
      0: if (sup_ok && !si) nx = 1;
      1, 2: begin
        if (!sl) nx = 0;
        else if (trip) nx = 3;
        else if (!su || so) nx = 0;
        else if (m_st == 1 && sd && sg) nx = 2;
      end
      default: begin
        if (!sl) nx = 0;
        else if (m_cnt == 0 && m_rearm && su) nx = 0;
      end
    endcase
    gn  = (nx == 1) || (nx == 2);
    pgn = gn && (m_pg || (m_gate && sd && sg));
    if (m_st != 3 && nx == 3) m_cnt = L - 1;
    else if (m_st == 3 && m_cnt != 0) m_cnt = m_cnt - 1;
    m_rearm = (m_st == 3) && (nx == 3) && (m_rearm || !su);
    m_st    = nx;
    m_gate  = gn;
    m_reg   = gn && si;
    m_fault = (nx == 3);
    m_pg    = pgn;
    d2 = d1;
    d1 = {gf, dl, il, lk, ov, uv};
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (!rst) begin
      check({tag, " gate"},  gate_en,       m_gate);
      check({tag, " reg"},   reg_down,      m_reg);
      check({tag, " fault"}, fault_latched, m_fault);
      check({tag, " pg_lo"}, pgood,         !m_pg);
      check({tag, " pg_hi"}, pgood_h,       m_pg);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    repeat (3) step("R1");
    rst = 0;
    check("R1 gate after reset", gate_en, 1'b0);
    check("R1 reg after reset", reg_down, 1'b0);
    check("R1 fault after reset", fault_latched, 1'b0);
    check("R1 pgood low-active idle", pgood, 1'b1);
    check("R1 pgood high-active idle", pgood_h, 1'b0);

    // R2: start blocked by current limit, then enabled after 3 edges
    uv = 1; lk = 1; il = 1;
    repeat (4) step("R2");
    check("R2 blocked by ilim", gate_en, 1'b0);
    il = 0;
    repeat (2) step("R2");
    check("R2 not before 3 edges", gate_en, 1'b0);
    step("R2");
    check("R2 gate on", gate_en, 1'b1);

    // R4: regulation request without turn-off
    il = 1;
    repeat (3) step("R4");
    check("R4 reg_down", reg_down, 1'b1);
    check("R4 gate stays on", gate_en, 1'b1);
    il = 0;
    repeat (3) step("R4");
    check("R4 reg_down released", reg_down, 1'b0);

    // R9 / R10: power-good latch and polarity
    dl = 1; gf = 1;
    repeat (3) step("R9");
    check("R10 low-active good", pgood, 1'b0);
    check("R10 high-active good", pgood_h, 1'b1);
    dl = 0; gf = 0;
    repeat (3) step("R9");
    check("R9 pgood held", pgood, 1'b0);

    // R5 / R6 / R7: trip, early reset request, hold for L cycles
    trip = 1; step("R5"); trip = 0;
    check("R5 fault set", fault_latched, 1'b1);
    check("R5 gate off", gate_en, 1'b0);
    check("R9 pgood cleared", pgood, 1'b1);
    uv = 0; repeat (2) step("R7"); uv = 1;
    repeat (L - 3) step("R6");
    check("R6 still latched at L", fault_latched, 1'b1);
    step("R6");
    check("R7 released after L", fault_latched, 1'b0);
    step("R7");
    check("R7 gate back on", gate_en, 1'b1);

    // R7: no uv cycle keeps the fault
    trip = 1; step("R5"); trip = 0;
    repeat (L + 10) step("R7");
    check("R7 held without rearm", fault_latched, 1'b1);
    uv = 0; step("R7"); uv = 1;
    repeat (6) step("R7");
    check("R7 cleared by uv cycle", fault_latched, 1'b0);
    check("R2 restart after clear", gate_en, 1'b1);

    // R8: lockout clears fault early
    trip = 1; step("R5"); trip = 0;
    repeat (2) step("R8");
    lk = 0;
    repeat (3) step("R8");
    check("R8 fault cleared", fault_latched, 1'b0);
    check("R8 gate off", gate_en, 1'b0);

    // R11: trip while off
    trip = 1; step("R11"); trip = 0;
    check("R11 trip ignored", fault_latched, 1'b0);
    lk = 1;
    repeat (4) step("R8");
    check("R8 restart without wait", gate_en, 1'b1);

    // R3: overvoltage and undervoltage kill
    ov = 1; repeat (3) step("R3");
    check("R3 ov kills gate", gate_en, 1'b0);
    ov = 0; repeat (3) step("R3");
    check("R3 gate back", gate_en, 1'b1);
    uv = 0; repeat (2) step("R3");
    check("R3 not before 3 edges", gate_en, 1'b1);
    step("R3");
    check("R3 uv kills gate", gate_en, 1'b0);
    uv = 1;

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      uv   = ($urandom_range(99) < 92);
      ov   = ($urandom_range(99) < 5);
      lk   = ($urandom_range(99) < 98);
      il   = ($urandom_range(99) < 20);
      dl   = ($urandom_range(99) < 50);
      gf   = ($urandom_range(99) < 50);
      trip = ($urandom_range(99) < 3);
      step("R2 random");
    end
    trip = 0;
    step("R2 random");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule